// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block is the front end of a memory management unit. It takes a 32-bit virtual address, an access kind (read, write or execute) and a user/kernel flag, and produces a physical address, a 3-bit permission mask and a miss flag. Four configuration inputs steer the decision:

- a global configuration word, which switches translation on or off;
- a 16-bit segment map;
- two packed kernel-base words that hold one 4-bit base per segment.

When translation is off, the address passes through unchanged. When a privileged access falls in a mapped segment, the top nibble of the address is replaced by that segment's base. In both of these cases every permission is granted and no miss is reported.

Any other access is handed to an external page-translation port. This covers every user-mode access and every unmapped kernel access. The page port is told whether the access belongs on the instruction path or on the data path. The block returns the port's answer unchanged. A request is accepted with a valid/ready handshake. The result is registered and announced with a single-cycle done pulse.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, `done` and `pg_valid` are low and `req_ready` is high.
- R2: Translation is on only when bit 2 or bit 3 of `gcfg` is set. When it is off, the cycle after acceptance shows `done`=1, `res_paddr`=`req_vaddr`, `res_perm`=3'b111 and `res_miss`=0, and no page request is issued.
- R3: With translation on, a non-user access whose segment s=`req_vaddr[31:28]` has `seg_map[s]`=1 is mapped directly. The 4-bit base is taken from bits [4*(s&7)+3:4*(s&7)], read from `kbase_lo` for s<8 and from `kbase_hi` for s>=8. The result `res_paddr`={base, `req_vaddr[27:0]`}, with `res_perm`=3'b111 and `res_miss`=0, is given the cycle after acceptance.
- R4: With translation on, a user-mode access always goes to the page port, whatever `seg_map` holds.
- R5: A page request carries the accepted `req_vaddr` and `req_user` on `pg_vaddr` and `pg_user`, and `pg_valid` rises the cycle after acceptance.
- R6: `pg_instr` is 1 for access kind 2 (execute) and 0 for kinds 0, 1 and 3, which select the data path.
- R7: A page response is taken only while waiting for one, at a clock edge where `pg_rsp_valid` is high. The next cycle shows `done`=1 with `res_paddr`, `res_perm` and `res_miss` equal to the response. A response pulse at any other time has no effect.
- R8: `pg_valid` and `pg_vaddr` hold steady until `pg_ready` is seen, and `pg_valid` drops after that handshake. While a page request is outstanding, `req_ready` is low and `req_valid` is ignored.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: Access kind code 3 is handled as a read: `pg_kind` shows 0 (read) for it, and `pg_kind` never shows 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | Access made in user mode |
| gcfg | input | 32 | Global configuration; bits 2 and 3 enable translation |
| seg_map | input | 16 | One bit per segment: directly mapped |
| kbase_lo | input | 32 | Base nibbles for segments 0 to 7 |
| kbase_hi | input | 32 | Base nibbles for segments 8 to 15 |
| pg_valid | output | 1 | Page translation request |
| pg_ready | input | 1 | Page port accepts request |
| pg_vaddr | output | 32 | Address sent to the page port |
| pg_instr | output | 1 | 1 selects instruction path, 0 data path |
| pg_kind | output | 2 | Normalised access kind |
| pg_user | output | 1 | User flag sent to the page port |
| pg_rsp_valid | input | 1 | Page response present |
| pg_rsp_paddr | input | 32 | Page physical address |
| pg_rsp_perm | input | 3 | Page permissions (bit0 read, bit1 write, bit2 execute) |
| pg_rsp_miss | input | 1 | Page miss |
| done | output | 1 | Result valid pulse |
| res_paddr | output | 32 | Physical address |
| res_perm | output | 3 | Permission mask |
| res_miss | output | 1 | Miss flag |

## Verification
A direct result (translation off, or a mapped kernel segment) is due one cycle after the accepting edge. A page request shows on `pg_valid` one cycle after acceptance, drops one cycle after `pg_ready`, and the page result is due one cycle after the edge that takes `pg_rsp_valid`. The bench drives every input at a falling edge and samples at the next falling edge, so each check falls in the exact cycle named above. It also checks the following cycle to confirm that the done pulse has ended and that nothing was issued for requests made while busy.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int KIND_W   = 2;
    localparam int EN_BIT_A = 2;
    localparam int EN_BIT_B = 3;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;

    // Reserved kind code is folded onto a read.
    function automatic acc_kind_e norm_kind(input logic [KIND_W-1:0] k);
        acc_kind_e r;
        case (k)
            2'd1:    r = ACC_WRITE;
            2'd2:    r = ACC_EXEC;
            default: r = ACC_READ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seg_xlate_decode.sv
module seg_xlate_decode
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 4,
    parameter int CFG_W  = 32,
    localparam int NSEG  = 1 << SEG_W,
    localparam int HALF  = NSEG / 2,
    localparam int KB_W  = HALF * SEG_W,
    localparam int OFF_W = ADDR_W - SEG_W
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [KIND_W-1:0] kind,
    input  logic              user,
    input  logic [CFG_W-1:0]  gcfg,
    input  logic [NSEG-1:0]   seg_map,
    input  logic [KB_W-1:0]   kb_lo,
    input  logic [KB_W-1:0]   kb_hi,
    output logic              xl_on,
    output logic              fast,
    output logic [ADDR_W-1:0] fast_paddr,
    output logic              instr,
    output acc_kind_e         kind_n
);

    logic [SEG_W-1:0] seg;
    logic [SEG_W-1:0] base_tab [NSEG];
    logic [SEG_W-1:0] base;
    logic             mapped;
    logic             cfg_unused;

    assign seg = vaddr[ADDR_W-1 -: SEG_W];

    // One base nibble per segment: lower half from kb_lo, upper half from kb_hi.
    for (genvar g = 0; g < NSEG; g++) begin : g_base
        if (g < HALF) begin : g_lo
            assign base_tab[g] = kb_lo[(g % HALF)*SEG_W +: SEG_W];
        end else begin : g_hi
            assign base_tab[g] = kb_hi[(g % HALF)*SEG_W +: SEG_W];
        end
    end

    assign base       = base_tab[seg];
    assign xl_on      = gcfg[EN_BIT_A] | gcfg[EN_BIT_B];
    assign mapped     = xl_on && !user && seg_map[seg];
    assign fast       = !xl_on || mapped;
    assign fast_paddr = mapped ? {base, vaddr[OFF_W-1:0]} : vaddr;
    assign kind_n     = norm_kind(kind);
    assign instr      = (kind_n == ACC_EXEC);
    assign cfg_unused = ^gcfg;

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PERM_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_user,
    input  logic              fast,
    input  logic [ADDR_W-1:0] fast_paddr,
    input  logic              instr,
    input  acc_kind_e         kind_n,
    output logic              pg_valid,
    input  logic              pg_ready,
    output logic [ADDR_W-1:0] pg_vaddr,
    output logic              pg_instr,
    output logic [KIND_W-1:0] pg_kind,
    output logic              pg_user,
    input  logic              pg_rsp_valid,
    input  logic [ADDR_W-1:0] pg_rsp_paddr,
    input  logic [PERM_W-1:0] pg_rsp_perm,
    input  logic              pg_rsp_miss,
    output logic              done,
    output logic [ADDR_W-1:0] res_paddr,
    output logic [PERM_W-1:0] res_perm,
    output logic              res_miss
);

    localparam logic [PERM_W-1:0] PERM_ALL = '1;

    xl_state_e state;
    logic      accept;
    logic      take_rsp;

    assign req_ready = (state == ST_IDLE);
    assign pg_valid  = (state == ST_ISSUE);
    assign accept    = req_valid && req_ready;
    assign take_rsp  = (state == ST_WAIT) && pg_rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            res_paddr <= '0;
            res_perm  <= '0;
            res_miss  <= 1'b0;
            pg_vaddr  <= '0;
            pg_instr  <= 1'b0;
            pg_kind   <= '0;
            pg_user   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (fast) begin
                            res_paddr <= fast_paddr;
                            res_perm  <= PERM_ALL;
                            res_miss  <= 1'b0;
                            done      <= 1'b1;
                        end else begin
                            pg_vaddr <= req_vaddr;
                            pg_instr <= instr;
                            pg_kind  <= kind_n;
                            pg_user  <= req_user;
                            state    <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (pg_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (take_rsp) begin
                        res_paddr <= pg_rsp_paddr;
                        res_perm  <= pg_rsp_perm;
                        res_miss  <= pg_rsp_miss;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_issue_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ISSUE && !pg_ready) |=> (state == ST_ISSUE) && $stable(pg_vaddr));

    p_rsp_pass_r7: assert property (@(posedge clk) disable iff (rst)
        take_rsp |=> done && res_paddr == $past(pg_rsp_paddr)
                     && res_perm == $past(pg_rsp_perm) && res_miss == $past(pg_rsp_miss));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> state == ST_IDLE);

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 4,
    parameter int CFG_W  = 32,
    parameter int PERM_W = 3,
    localparam int NSEG  = 1 << SEG_W,
    localparam int KB_W  = (NSEG / 2) * SEG_W,
    localparam int OFF_W = ADDR_W - SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              req_user,
    input  logic [CFG_W-1:0]  gcfg,
    input  logic [NSEG-1:0]   seg_map,
    input  logic [KB_W-1:0]   kbase_lo,
    input  logic [KB_W-1:0]   kbase_hi,
    output logic              pg_valid,
    input  logic              pg_ready,
    output logic [ADDR_W-1:0] pg_vaddr,
    output logic              pg_instr,
    output logic [KIND_W-1:0] pg_kind,
    output logic              pg_user,
    input  logic              pg_rsp_valid,
    input  logic [ADDR_W-1:0] pg_rsp_paddr,
    input  logic [PERM_W-1:0] pg_rsp_perm,
    input  logic              pg_rsp_miss,
    output logic              done,
    output logic [ADDR_W-1:0] res_paddr,
    output logic [PERM_W-1:0] res_perm,
    output logic              res_miss
);

    logic              xl_on;
    logic              fast;
    logic [ADDR_W-1:0] fast_paddr;
    logic              instr;
    acc_kind_e         kind_n;

    seg_xlate_decode #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .CFG_W(CFG_W)
    ) u_decode (
        .vaddr     (req_vaddr),
        .kind      (req_kind),
        .user      (req_user),
        .gcfg      (gcfg),
        .seg_map   (seg_map),
        .kb_lo     (kbase_lo),
        .kb_hi     (kbase_hi),
        .xl_on     (xl_on),
        .fast      (fast),
        .fast_paddr(fast_paddr),
        .instr     (instr),
        .kind_n    (kind_n)
    );

    seg_xlate_ctrl #(
        .ADDR_W(ADDR_W), .PERM_W(PERM_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_vaddr   (req_vaddr),
        .req_user    (req_user),
        .fast        (fast),
        .fast_paddr  (fast_paddr),
        .instr       (instr),
        .kind_n      (kind_n),
        .pg_valid    (pg_valid),
        .pg_ready    (pg_ready),
        .pg_vaddr    (pg_vaddr),
        .pg_instr    (pg_instr),
        .pg_kind     (pg_kind),
        .pg_user     (pg_user),
        .pg_rsp_valid(pg_rsp_valid),
        .pg_rsp_paddr(pg_rsp_paddr),
        .pg_rsp_perm (pg_rsp_perm),
        .pg_rsp_miss (pg_rsp_miss),
        .done        (done),
        .res_paddr   (res_paddr),
        .res_perm    (res_perm),
        .res_miss    (res_miss)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !done && !pg_valid && req_ready);

    p_off_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !gcfg[EN_BIT_A] && !gcfg[EN_BIT_B])
        |=> done && res_paddr == $past(req_vaddr) && res_perm == '1 && !res_miss && !pg_valid);

    p_seg_low_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && xl_on && !req_user && seg_map[req_vaddr[ADDR_W-1 -: SEG_W]])
        |=> done && !res_miss && res_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

    p_user_page_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && xl_on && req_user) |=> pg_valid && !done);

    p_fwd_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_valid) |-> pg_vaddr == $past(req_vaddr) && pg_user == $past(req_user));

    p_path_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_valid) |-> pg_instr == ($past(req_kind) == 2'd2));

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        pg_valid |-> !req_ready);

    p_kind_r10: assert property (@(posedge clk) disable iff (rst)
        pg_valid |-> pg_kind != 2'd3);

endmodule

// File: tb/seg_xlate_top_bench.sv
module seg_xlate_top_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [31:0] gcfg = '0;
    logic [15:0] seg_map = '0;
    logic [31:0] kbase_lo = '0;
    logic [31:0] kbase_hi = '0;
    logic        pg_valid;
    logic        pg_ready = 1'b0;
    logic [31:0] pg_vaddr;
    logic        pg_instr;
    logic [1:0]  pg_kind;
    logic        pg_user;
    logic        pg_rsp_valid = 1'b0;
    logic [31:0] pg_rsp_paddr = '0;
    logic [2:0]  pg_rsp_perm = '0;
    logic        pg_rsp_miss = 1'b0;
    logic        done;
    logic [31:0] res_paddr;
    logic [2:0]  res_perm;
    logic        res_miss;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    seg_xlate_top u_seg_xlate_top (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit f_on(input logic [31:0] g);
        return g[2] | g[3];
    endfunction

    function automatic bit f_fast(input logic [31:0] va, input bit u, input logic [31:0] g,
                                  input logic [15:0] m);
        if (!f_on(g)) return 1'b1;
        return !u && m[va[31:28]];
    endfunction

    function automatic logic [31:0] f_paddr(input logic [31:0] va, input logic [31:0] g,
                                            input logic [31:0] lo, input logic [31:0] hi);
        logic [3:0]  s;
        logic [31:0] src;
        logic [3:0]  nib;
        if (!f_on(g)) return va;
        s   = va[31:28];
        src = s[3] ? hi : lo;
        nib = 4'((src >> (4 * s[2:0])) & 32'hf);
        return {nib, va[27:0]};
    endfunction

    task automatic run_req(input logic [31:0] va, input logic [1:0] k, input bit u,
                           input logic [31:0] g, input logic [15:0] m,
                           input logic [31:0] lo, input logic [31:0] hi, input bit poke);
        bit          fst;
        logic [31:0] rp;
        logic [2:0]  rperm;
        bit          rmiss;
        int          stall;
        int          dly;
        fst = f_fast(va, u, g, m);
        @(negedge clk);
        req_vaddr = va; req_kind = k; req_user = u;
        gcfg = g; seg_map = m; kbase_lo = lo; kbase_hi = hi;
        req_valid = 1'b1;
        chk("R8 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (fst) begin
            chk(f_on(g) ? "R3 done" : "R2 done", done, 1);
            chk(f_on(g) ? "R3 paddr" : "R2 paddr", res_paddr, f_paddr(va, g, lo, hi));
            chk("R2/R3 perm", res_perm, 3'b111);
            chk("R2/R3 miss", res_miss, 0);
            chk("R2 no page request", pg_valid, 0);
        end else begin
            chk(u ? "R4 user to page" : "R5 unmapped to page", pg_valid, 1);
            chk("R5 pg_vaddr", pg_vaddr, va);
            chk("R5 pg_user", pg_user, u);
            chk("R6 pg_instr", pg_instr, (k == 2'd2));
            chk("R10 pg_kind", pg_kind, (k == 2'd3) ? 2'd0 : k);
            chk("R7 no early done", done, 0);
            chk("R8 busy not ready", req_ready, 0);
            stall = $urandom_range(0, 3);
            for (int i = 0; i < stall; i++) begin
                if (poke && i == 0) begin
                    req_valid = 1'b1;
                    req_vaddr = ~va;
                end
                @(negedge clk);
                req_valid = 1'b0;
                req_vaddr = va;
                chk("R8 hold valid", pg_valid, 1);
                chk("R8 hold vaddr", pg_vaddr, va);
            end
            pg_ready = 1'b1;
            @(negedge clk);
            pg_ready = 1'b0;
            chk("R8 drop after handshake", pg_valid, 0);
            dly = $urandom_range(0, 2);
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk("R7 wait no done", done, 0);
            end
            rp = $urandom; rperm = 3'($urandom); rmiss = 1'($urandom);
            pg_rsp_valid = 1'b1; pg_rsp_paddr = rp; pg_rsp_perm = rperm; pg_rsp_miss = rmiss;
            @(negedge clk);
            pg_rsp_valid = 1'b0;
            chk("R7 done", done, 1);
            chk("R7 paddr", res_paddr, rp);
            chk("R7 perm", res_perm, rperm);
            chk("R7 miss", res_miss, rmiss);
        end
        @(negedge clk);
        chk("R9 single pulse", done, 0);
        chk("R8 ignored request issued nothing", pg_valid, 0);
        chk("R8 idle again", req_ready, 1);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 done low", done, 0);
        chk("R1 pg_valid low", pg_valid, 0);
        chk("R1 ready high", req_ready, 1);
        rst = 1'b0;
        // Stray response while idle must not produce a result (R7).
        @(negedge clk);
        pg_rsp_valid = 1'b1;
        @(negedge clk);
        pg_rsp_valid = 1'b0;
        chk("R7 stray response ignored", done, 0);

        // R2: translation off, including other config bits set.
        run_req(32'hDEAD_BEEF, 2'd0, 1'b0, 32'h0, 16'hFFFF, 32'h1234_5678, 32'h9ABC_DEF0, 0);
        run_req(32'h8000_0010, 2'd2, 1'b1, 32'h0000_0013, 16'hFFFF, 32'h0, 32'h0, 0);
        // R3: mapped segments at both register halves and edges.
        run_req(32'h0123_4567, 2'd0, 1'b0, 32'h4, 16'h0001, 32'h7654_321A, 32'h0, 0);
        run_req(32'h7FFF_FFFF, 2'd1, 1'b0, 32'h4, 16'h0080, 32'hB000_0000, 32'h0, 0);
        run_req(32'h8000_0001, 2'd2, 1'b0, 32'h8, 16'h0100, 32'h0, 32'h0000_000C, 0);
        run_req(32'hF00D_CAFE, 2'd0, 1'b0, 32'hC, 16'h8000, 32'hFFFF_FFFF, 32'h5000_0000, 0);
        // R4: user mode always goes to the page port.
        run_req(32'hC000_1000, 2'd0, 1'b1, 32'h4, 16'hFFFF, 32'h0, 32'h0, 0);
        // R5/R6/R10: unmapped kernel, each kind, with a request while busy (R8).
        run_req(32'h4000_2000, 2'd2, 1'b0, 32'h8, 16'h0000, 32'h0, 32'h0, 1);
        run_req(32'h5000_3000, 2'd3, 1'b0, 32'h4, 16'h0000, 32'h0, 32'h0, 1);
        run_req(32'h6000_4000, 2'd1, 1'b1, 32'h4, 16'h0000, 32'h0, 32'h0, 1);

        for (int n = 0; n < 300; n++) begin
            logic [31:0] g;
            g = $urandom;
            if ($urandom_range(0, 3) == 0) g[3:2] = 2'b00;
            run_req($urandom, 2'($urandom), ($urandom_range(0, 2) == 0), g,
                    16'($urandom), $urandom, $urandom, 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule